// File: doc/BRIEF.md
# Bank-Switched Host Register Window

This block gives a host a small register window of sixteen byte addresses, organised as eight 16-bit words, behind which four banks of registers sit. The host picks which bank the window shows by writing a bank number into a bank select word. That word occupies the last word of the window and is reachable the same way from every bank, so the host can always switch banks.

The host bus is a plain synchronous 16-bit interface: a word address, two byte-lane enables, a write strobe, a read strobe, write data and registered read data. Behind the window, most words are plain read/write holding registers with per-byte write enables. One word in bank 0 is reserved. One word in bank 3 is a read-only revision word: a chip identifier in the high byte and a revision number in the low byte. The select word also returns a fixed identification byte in its upper half, so software can probe for the block.

Top module: `banked_reg_window`

## Requirements
- R1: After reset the selected bank is 0, the read data output is 0x0000, and every holding register reads 0x0000.
- R2: A write to word 7 with byte enable 0 set loads write data bits 1:0 into the bank select, and all later accesses to words 0 to 6 reach the newly selected bank.
- R3: Word 7 (byte offset 0x0E) reaches the bank select from every bank, whichever bank is currently selected.
- R4: A read of word 7 returns 0x33 in bits 15:8, zeros in bits 7:2 and the current bank number in bits 1:0.
- R5: Writes to bits 15:8 of word 7 are ignored, and write data bits 7:2 of word 7 are discarded; a word 7 write with byte enable 0 clear leaves the bank unchanged.
- R6: Byte enable bit 1 (the odd byte address) writes bits 15:8 and byte enable bit 0 (the even byte address) writes bits 7:0; a lane whose enable is clear keeps its old value.
- R7: Every bank has its own storage: a write to a word in one bank does not change the same word in any other bank.
- R8: Bank 0 word 6 (byte offset 0x0C) is reserved: it reads 0x0000 and writes to it have no effect.
- R9: Bank 3 word 5 (byte offset 0x0A) reads the chip identifier 0x5C in bits 15:8 and revision 0x02 in bits 7:0, and writes to it have no effect.
- R10: Read data is registered: it takes the addressed value on the clock edge that samples the read strobe and holds its value on every edge without a read strobe.
- R11: When a read and a write reach the same word in the same cycle, the read returns the value from before the write, and the bank used for decode is the one selected before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 3 | Word index within the window (byte address bits 3:1) |
| bus_be | input | 2 | Byte-lane enables: bit 1 high byte, bit 0 low byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The bench aims at the bank select word from every bank, with writes that set only the high lane or carry junk in bits 7:2; a design that let those through would show a wrong identification byte or jump to an unexpected bank. It writes single lanes to holding registers, where a design that merged lanes wrongly would corrupt the untouched byte, and writes the same offset in several banks, where shared storage would leak values across banks. It writes to the reserved and revision words, which a careless decoder would store, and it issues reads and writes to one word in the same cycle, where a design that forwarded write data or decoded with the new bank would return the post-write value.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  typedef enum logic [1:0] {
    K_RW   = 2'd0,
    K_RSVD = 2'd1,
    K_REV  = 2'd2,
    K_SEL  = 2'd3
  } word_kind_e;

  // Role of a given word of a given bank inside the window.
  function automatic word_kind_e classify(input int bank, input int word,
                                          input int sel_word,
                                          input int rsvd_bank, input int rsvd_word,
                                          input int rev_bank, input int rev_word);
    if (word == sel_word) return K_SEL;
    if (bank == rsvd_bank && word == rsvd_word) return K_RSVD;
    if (bank == rev_bank && word == rev_word) return K_REV;
    return K_RW;
  endfunction

endpackage

// File: rtl/bw_lane_reg.sv
module bw_lane_reg #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LANES-1:0]   be,
  input  logic [LANES*8-1:0] wdata,
  output logic [LANES*8-1:0] q
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_d;

    always_comb begin
      lane_en = wr_en & be[l];
      lane_d  = wdata[l*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[l*8 +: 8] <= '0;
      else if (lane_en) q[l*8 +: 8] <= lane_d;
    end
  end

endmodule

// File: rtl/bw_bank_sel.sv
module bw_bank_sel #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [BANK_W-1:0] sel_d,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (sel_wr) bank_d = sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

endmodule

// File: rtl/bw_read_port.sv
module bw_read_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata;
    if (rd_en) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/banked_reg_window.sv
module banked_reg_window #(
  parameter int         NUM_BANKS = 4,
  parameter int         ADDR_W    = 3,
  parameter int         DATA_W    = 16,
  parameter int         RSVD_BANK = 0,
  parameter int         RSVD_WORD = 6,
  parameter int         REV_BANK  = 3,
  parameter int         REV_WORD  = 5,
  parameter logic [7:0] ID_BYTE   = 8'h33,
  parameter logic [7:0] CHIP_ID   = 8'h5C,
  parameter logic [7:0] REV_NUM   = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import bankwin_pkg::*;

  localparam int WORDS    = 1 << ADDR_W;
  localparam int SEL_WORD = WORDS - 1;
  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int LANES    = DATA_W / 8;
  localparam int SLOTS    = NUM_BANKS * WORDS;

  logic [BANK_W-1:0] bank_q;
  logic              sel_hit;
  logic              sel_wr;
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [DATA_W-1:0] sel_view;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    sel_hit  = (bus_addr == ADDR_W'(SEL_WORD));
    sel_wr   = bus_wr & sel_hit & bus_be[0];
    sel_view = '0;
    sel_view[DATA_W-1 -: 8]  = ID_BYTE;
    sel_view[BANK_W-1:0]     = bank_q;
  end

  bw_bank_sel #(.BANK_W(BANK_W)) u_bank_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_wr (sel_wr),
    .sel_d  (bus_wdata[BANK_W-1:0]),
    .bank_q (bank_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam word_kind_e KIND = classify(b, w, SEL_WORD, RSVD_BANK, RSVD_WORD,
                                             REV_BANK, REV_WORD);
      if (KIND == K_RW) begin : g_rw
        logic hit_wr;
        always_comb hit_wr = bus_wr & (bank_q == BANK_W'(b)) & (bus_addr == ADDR_W'(w));
        bw_lane_reg #(.LANES(LANES)) u_reg (
          .clk   (clk),
          .rst_n (rst_n),
          .wr_en (hit_wr),
          .be    (bus_be[LANES-1:0]),
          .wdata (bus_wdata),
          .q     (slot_q[b*WORDS + w])
        );
      end else if (KIND == K_REV) begin : g_rev
        assign slot_q[b*WORDS + w] = {{(DATA_W-16){1'b0}}, CHIP_ID, REV_NUM};
      end else begin : g_zero
        assign slot_q[b*WORDS + w] = '0;
      end
    end
  end

  always_comb begin
    if (sel_hit) rd_word = sel_view;
    else         rd_word = slot_q[{bank_q, bus_addr}];
  end

  bw_read_port #(.DATA_W(DATA_W)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_rd),
    .rd_word (rd_word),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/bw_window_chk.sv
module bw_window_chk #(
  parameter int         ADDR_W    = 3,
  parameter int         DATA_W    = 16,
  parameter int         BANK_W    = 2,
  parameter int         RSVD_BANK = 0,
  parameter int         RSVD_WORD = 6,
  parameter int         REV_BANK  = 3,
  parameter int         REV_WORD  = 5,
  parameter logic [7:0] ID_BYTE   = 8'h33,
  parameter logic [7:0] CHIP_ID   = 8'h5C,
  parameter logic [7:0] REV_NUM   = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_be,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [BANK_W-1:0] bank
);
  localparam logic [ADDR_W-1:0] SELW = '1;

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SELW && bus_be[0]) |=> (bank == $past(bus_wdata[BANK_W-1:0])));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr == SELW && bus_be[0])) |=> $stable(bank));

  // R4
  sel_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == SELW) |=>
      (bus_rdata[DATA_W-1 -: 8] == ID_BYTE && bus_rdata[7:BANK_W] == '0));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bank == BANK_W'(RSVD_BANK) && bus_addr == ADDR_W'(RSVD_WORD)) |=>
      (bus_rdata == '0));

  // R9
  rev_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bank == BANK_W'(REV_BANK) && bus_addr == ADDR_W'(REV_WORD)) |=>
      (bus_rdata[15:0] == {CHIP_ID, REV_NUM}));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata));

endmodule

bind banked_reg_window bw_window_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .RSVD_BANK(RSVD_BANK), .RSVD_WORD(RSVD_WORD),
  .REV_BANK(REV_BANK), .REV_WORD(REV_WORD),
  .ID_BYTE(ID_BYTE), .CHIP_ID(CHIP_ID), .REV_NUM(REV_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bank(bank_q)
);

// File: tb/tb_banked_reg_window.sv
`timescale 1ns/1ps
module tb_banked_reg_window;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_be;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model
  int m_reg [4][8];
  int m_bank = 0;
  int m_rd   = 0;

  banked_reg_window dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int model_read(int a);
    if (a == 7) return 16'h3300 | m_bank;
    if (m_bank == 0 && a == 6) return 0;
    if (m_bank == 3 && a == 5) return 16'h5C02;
    return m_reg[m_bank][a];
  endfunction

  task automatic model_write(int a, int be, int wd);
    if (a == 7) begin
      if (be & 1) m_bank = wd & 3;
    end else if (!(m_bank == 0 && a == 6) && !(m_bank == 3 && a == 5)) begin
      if (be & 1) m_reg[m_bank][a] = (m_reg[m_bank][a] & 16'hFF00) | (wd & 16'h00FF);
      if (be & 2) m_reg[m_bank][a] = (m_reg[m_bank][a] & 16'h00FF) | (wd & 16'hFF00);
    end
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %04h expected %04h", tag, got, exp);
    end
  endtask

  // One bus cycle; model and DUT are compared after every clock edge.
  task automatic step(string tag, int a, int be, bit we, bit re, int wd);
    @(negedge clk);
    bus_addr = 3'(a); bus_be = 2'(be); bus_wr = we; bus_rd = re; bus_wdata = 16'(wd);
    @(posedge clk);
    if (re) m_rd = model_read(a);
    if (we) model_write(a, be, wd);
    #1;
    chk(tag, int'(bus_rdata), m_rd);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_reg[b, w]) m_reg[b][w] = 0;
    rst_n = 1'b0; bus_addr = '0; bus_be = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle("R1");
    step("R1", 7, 3, 0, 1, 0);
    for (int b = 0; b < 4; b++) begin
      step("R1", 7, 1, 1, 0, b);
      for (int w = 0; w < 7; w++) step("R1", w, 0, 0, 1, 0);
    end
    step("R2", 7, 1, 1, 0, 0);

    // R6: byte lanes
    step("R6", 0, 3, 1, 0, 16'hA5C3);
    step("R6", 0, 0, 0, 1, 0);
    step("R6", 0, 2, 1, 0, 16'h7755);
    step("R6", 0, 0, 0, 1, 0);
    step("R6", 0, 1, 1, 0, 16'h9911);
    step("R6", 0, 0, 0, 1, 0);

    // R2 / R3 / R4 / R7
    step("R2", 7, 1, 1, 0, 2);
    step("R4", 7, 3, 0, 1, 0);
    step("R7", 0, 3, 1, 0, 16'h1234);
    step("R7", 0, 3, 0, 1, 0);
    step("R3", 7, 1, 1, 0, 0);
    step("R7", 0, 3, 0, 1, 0);
    for (int b = 0; b < 4; b++) begin
      step("R3", 7, 1, 1, 0, b);
      step("R3", 7, 3, 0, 1, 0);
    end

    // R5: upper byte and bits 7:2 of select ignored
    step("R5", 7, 3, 1, 0, 16'hFFFD);
    step("R5", 7, 3, 0, 1, 0);
    step("R5", 7, 2, 1, 0, 16'hFF03);
    step("R5", 7, 3, 0, 1, 0);

    // R8: reserved word
    step("R8", 7, 1, 1, 0, 0);
    step("R8", 6, 3, 1, 0, 16'hFFFF);
    step("R8", 6, 3, 0, 1, 0);
    step("R8", 7, 1, 1, 0, 1);
    step("R8", 6, 3, 1, 0, 16'hBEEF);
    step("R8", 6, 3, 0, 1, 0);

    // R9: revision word
    step("R9", 7, 1, 1, 0, 3);
    step("R9", 5, 3, 0, 1, 0);
    step("R9", 5, 3, 1, 0, 16'h0000);
    step("R9", 5, 3, 0, 1, 0);

    // R10: hold without read strobe
    step("R10", 4, 3, 1, 0, 16'h4444);
    idle("R10");
    step("R10", 4, 3, 0, 1, 0);
    step("R10", 1, 3, 1, 0, 16'h0101);

    // R11: read-before-write in one cycle, and bank switch with read
    step("R11", 1, 3, 1, 1, 16'hCAFE);
    step("R11", 1, 3, 0, 1, 0);
    step("R11", 7, 1, 1, 1, 2);
    step("R11", 7, 3, 0, 1, 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      step("R2", int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule